// File: doc/BRIEF.md
# IOMMU Invalidation Command Dispatcher

This block sits behind the command-queue reader of an address-translation unit. Each cycle it may accept one decoded command (opcode plus stream identifier, secure flag, address-space and virtual-machine identifiers and a range exponent). It turns that command into exactly one of three things: a configuration-cache flush over a stream-ID window, a TLB invalidation with a scope, or an illegal-command error. A third case produces nothing at all: a config invalidation aimed at a stream with no device behind it.

Which translation stages the unit implements is given on two static capability inputs. These inputs decide more than legality. Without stage 2, VMIDs are not compared and are reported as a wildcard. Without stage 2, an invalidate-all of stage-1 entries falls through to a global invalidate-all. Commands are accepted when `cmd_valid` is high. The result appears as a one-cycle pulse in the next cycle.

Top module: `inv_dispatch`

## Requirements
- R1: Opcode encoding (8 bits): 0x03 config by stream, 0x04 config by stream range, 0x05 config by context, 0x06 config all contexts of a stream, 0x10 stage-1 all, 0x11 stage-1 by ASID, 0x12 stage-1 by address, 0x28 stage-1+2 by VMID, 0x2A stage-2 by IPA, 0x30 global all. The result of a command sampled with `cmd_valid` high appears on the outputs exactly one clock later. It lasts one cycle. At most one of `cfg_flush_valid`, `tlb_inv_valid` and `err_valid` is high. With `cmd_valid` low, all three stay low. After reset all outputs are 0.
- R2: A config invalidation by stream or by context (0x03, 0x05, 0x06) with `cmd_secure`=1 gives `err_valid` with `err_code`=1.
- R3: A non-secure 0x03/0x05/0x06 gives a flush with `cfg_sid_lo`=`cfg_sid_hi`=`cmd_sid` when `dev_present`=1. When `dev_present`=0 it gives no output and no error.
- R4: A range flush (0x04) covers `cfg_sid_lo` = `cmd_sid` with its low `cmd_range`+1 bits cleared through `cfg_sid_hi` = `cfg_sid_lo` with those bits set. It covers the whole ID space once `cmd_range`+1 reaches the ID width.
- R5: Opcodes 0x10, 0x11 and 0x12 give an error with code 1 when `cap_s1`=0.
- R6: 0x11 gives scope 2 (ASID) carrying `cmd_asid`. With `cap_s2`=1 it carries `cmd_vmid` and `tlb_vmid_any`=0. With `cap_s2`=0 it carries VMID 0 and `tlb_vmid_any`=1.
- R7: 0x10 with `cap_s2`=1 gives scope 1 (stage-1 entries of one VMID) with `cmd_vmid`. With `cap_s2`=0 it gives scope 0 (all) with `tlb_vmid_any`=1.
- R8: 0x30 always gives scope 0 with `tlb_vmid_any`=1, whatever the capabilities are.
- R9: 0x28 and 0x2A give an error with code 1 when `cap_s2`=0. Otherwise they give scope 4 (VMID, both stages) or scope 5 (stage-2 IPA) with `cmd_vmid`.
- R10: 0x12 gives scope 3 (stage-1 address) with `cmd_asid`. Its VMID follows the same rule as R6.
- R11: Any other opcode gives an error with code 1. `err_code` is 0 whenever `err_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_op | input | 8 | Command opcode |
| cmd_sid | input | SID_W | Stream identifier |
| cmd_secure | input | 1 | Secure-stream flag of config commands |
| cmd_asid | input | ASID_W | Address-space identifier |
| cmd_vmid | input | VMID_W | Virtual-machine identifier |
| cmd_range | input | RANGE_W | Range exponent for stream-range flush |
| dev_present | input | 1 | A device is attached at `cmd_sid` |
| cap_s1 | input | 1 | Stage 1 implemented |
| cap_s2 | input | 1 | Stage 2 implemented |
| cfg_flush_valid | output | 1 | Config-cache flush pulse |
| cfg_sid_lo | output | SID_W | First stream ID to flush |
| cfg_sid_hi | output | SID_W | Last stream ID to flush |
| tlb_inv_valid | output | 1 | TLB invalidation pulse |
| tlb_scope | output | 3 | Invalidation scope code |
| tlb_asid | output | ASID_W | ASID to match |
| tlb_vmid | output | VMID_W | VMID to match |
| tlb_vmid_any | output | 1 | VMID is a wildcard |
| err_valid | output | 1 | Illegal-command pulse |
| err_code | output | 2 | Error code (1 = illegal) |

## Verification
The assertions assume that `cap_s1` and `cap_s2` change only between commands and never while a result is in flight. The legality properties compare the capability inputs from the command cycle with the error one cycle later. The stimulus sets the capability bits in the same cycle as each command and holds them until the result has been sampled. The stimulus never raises `cmd_valid` twice back to back, so each result can be tied to one command. The opcodes used cover every listed code on both sides of each capability bit, plus unlisted codes.

// File: rtl/inv_pkg.sv
package inv_pkg;
   localparam int OP_W = 8;

   localparam logic [OP_W-1:0] OP_CFG_SID      = 8'h03;
   localparam logic [OP_W-1:0] OP_CFG_SID_SPAN = 8'h04;
   localparam logic [OP_W-1:0] OP_CFG_CTX      = 8'h05;
   localparam logic [OP_W-1:0] OP_CFG_CTX_ALL  = 8'h06;
   localparam logic [OP_W-1:0] OP_S1_ALL       = 8'h10;
   localparam logic [OP_W-1:0] OP_S1_ASID      = 8'h11;
   localparam logic [OP_W-1:0] OP_S1_ADDR      = 8'h12;
   localparam logic [OP_W-1:0] OP_S12_VM       = 8'h28;
   localparam logic [OP_W-1:0] OP_S2_IPA       = 8'h2A;
   localparam logic [OP_W-1:0] OP_GLOBAL_ALL   = 8'h30;

   typedef enum logic [2:0] {
      SC_ALL     = 3'd0,
      SC_S1_VM   = 3'd1,
      SC_ASID    = 3'd2,
      SC_S1_ADDR = 3'd3,
      SC_S12_VM  = 3'd4,
      SC_S2_IPA  = 3'd5
   } scope_e;

   typedef enum logic [1:0] {
      EC_NONE    = 2'd0,
      EC_ILLEGAL = 2'd1
   } errc_e;
endpackage

// File: rtl/inv_span_mask.sv
module inv_span_mask #(
   parameter int SID_W   = 16,
   parameter int RANGE_W = 5
) (
   input  logic [RANGE_W-1:0] range_i,
   input  logic [SID_W-1:0]   sid_i,
   output logic [SID_W-1:0]   lo_o,
   output logic [SID_W-1:0]   hi_o
);
   logic [SID_W-1:0] mask;

   for (genvar i = 0; i < SID_W; i++) begin : g_bit
      assign mask[i] = (int'(range_i) >= i);
   end

   assign lo_o = sid_i & ~mask;
   assign hi_o = sid_i | mask;
endmodule

// File: rtl/inv_cmd_decode.sv
module inv_cmd_decode
   import inv_pkg::*;
(
   input  logic [OP_W-1:0] op_i,
   input  logic            secure_i,
   input  logic            dev_i,
   input  logic            s1_i,
   input  logic            s2_i,
   output logic            do_cfg_o,
   output logic            do_span_o,
   output logic            do_tlb_o,
   output logic            do_err_o,
   output scope_e          scope_o,
   output logic            keep_asid_o,
   output logic            keep_vmid_o,
   output logic            any_vmid_o
);
   always_comb begin
      do_cfg_o    = 1'b0;
      do_span_o   = 1'b0;
      do_tlb_o    = 1'b0;
      do_err_o    = 1'b0;
      scope_o     = SC_ALL;
      keep_asid_o = 1'b0;
      keep_vmid_o = 1'b0;
      any_vmid_o  = 1'b0;
      case (op_i)
         OP_CFG_SID, OP_CFG_CTX, OP_CFG_CTX_ALL: begin
            if (secure_i)   do_err_o = 1'b1;
            else if (dev_i) do_cfg_o = 1'b1;
         end
         OP_CFG_SID_SPAN: begin
            do_cfg_o  = 1'b1;
            do_span_o = 1'b1;
         end
         OP_S1_ASID, OP_S1_ADDR: begin
            if (!s1_i) do_err_o = 1'b1;
            else begin
               do_tlb_o    = 1'b1;
               scope_o     = (op_i == OP_S1_ASID) ? SC_ASID : SC_S1_ADDR;
               keep_asid_o = 1'b1;
               keep_vmid_o = s2_i;
               any_vmid_o  = !s2_i;
            end
         end
         OP_S1_ALL: begin
            if (!s1_i) do_err_o = 1'b1;
            else if (s2_i) begin
               do_tlb_o    = 1'b1;
               scope_o     = SC_S1_VM;
               keep_vmid_o = 1'b1;
            end else begin
               do_tlb_o   = 1'b1;
               scope_o    = SC_ALL;
               any_vmid_o = 1'b1;
            end
         end
         OP_GLOBAL_ALL: begin
            do_tlb_o   = 1'b1;
            scope_o    = SC_ALL;
            any_vmid_o = 1'b1;
         end
         OP_S12_VM, OP_S2_IPA: begin
            if (!s2_i) do_err_o = 1'b1;
            else begin
               do_tlb_o    = 1'b1;
               scope_o     = (op_i == OP_S12_VM) ? SC_S12_VM : SC_S2_IPA;
               keep_vmid_o = 1'b1;
            end
         end
         default: do_err_o = 1'b1;
      endcase
   end
endmodule

// File: rtl/inv_dispatch.sv
module inv_dispatch
   import inv_pkg::*;
#(
   parameter int SID_W   = 16,
   parameter int ASID_W  = 16,
   parameter int VMID_W  = 16,
   parameter int RANGE_W = 5
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cmd_valid,
   input  logic [7:0]         cmd_op,
   input  logic [SID_W-1:0]   cmd_sid,
   input  logic               cmd_secure,
   input  logic [ASID_W-1:0]  cmd_asid,
   input  logic [VMID_W-1:0]  cmd_vmid,
   input  logic [RANGE_W-1:0] cmd_range,
   input  logic               dev_present,
   input  logic               cap_s1,
   input  logic               cap_s2,
   output logic               cfg_flush_valid,
   output logic [SID_W-1:0]   cfg_sid_lo,
   output logic [SID_W-1:0]   cfg_sid_hi,
   output logic               tlb_inv_valid,
   output logic [2:0]         tlb_scope,
   output logic [ASID_W-1:0]  tlb_asid,
   output logic [VMID_W-1:0]  tlb_vmid,
   output logic               tlb_vmid_any,
   output logic               err_valid,
   output logic [1:0]         err_code
);
   if (SID_W < 1 || ASID_W < 1 || VMID_W < 1 || RANGE_W < 1) begin : g_bad_width
      $error("inv_dispatch: every width must be at least 1");
   end
   if (OP_W != 8) begin : g_bad_op
      $error("inv_dispatch: opcode field must be 8 bits");
   end

   logic       d_cfg, d_span, d_tlb, d_err, d_keep_asid, d_keep_vmid, d_any;
   scope_e     d_scope;
   logic [SID_W-1:0] span_lo, span_hi;

   inv_cmd_decode u_dec (
      .op_i        (cmd_op),
      .secure_i    (cmd_secure),
      .dev_i       (dev_present),
      .s1_i        (cap_s1),
      .s2_i        (cap_s2),
      .do_cfg_o    (d_cfg),
      .do_span_o   (d_span),
      .do_tlb_o    (d_tlb),
      .do_err_o    (d_err),
      .scope_o     (d_scope),
      .keep_asid_o (d_keep_asid),
      .keep_vmid_o (d_keep_vmid),
      .any_vmid_o  (d_any)
   );

   inv_span_mask #(.SID_W(SID_W), .RANGE_W(RANGE_W)) u_span (
      .range_i (cmd_range),
      .sid_i   (cmd_sid),
      .lo_o    (span_lo),
      .hi_o    (span_hi)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_flush_valid <= 1'b0;
         cfg_sid_lo      <= '0;
         cfg_sid_hi      <= '0;
         tlb_inv_valid   <= 1'b0;
         tlb_scope       <= '0;
         tlb_asid        <= '0;
         tlb_vmid        <= '0;
         tlb_vmid_any    <= 1'b0;
         err_valid       <= 1'b0;
         err_code        <= EC_NONE;
      end else begin
         cfg_flush_valid <= cmd_valid && d_cfg;
         cfg_sid_lo      <= (cmd_valid && d_cfg) ? (d_span ? span_lo : cmd_sid) : '0;
         cfg_sid_hi      <= (cmd_valid && d_cfg) ? (d_span ? span_hi : cmd_sid) : '0;
         tlb_inv_valid   <= cmd_valid && d_tlb;
         tlb_scope       <= (cmd_valid && d_tlb) ? d_scope : SC_ALL;
         tlb_asid        <= (cmd_valid && d_tlb && d_keep_asid) ? cmd_asid : '0;
         tlb_vmid        <= (cmd_valid && d_tlb && d_keep_vmid) ? cmd_vmid : '0;
         tlb_vmid_any    <= cmd_valid && d_tlb && d_any;
         err_valid       <= cmd_valid && d_err;
         err_code        <= (cmd_valid && d_err) ? EC_ILLEGAL : EC_NONE;
      end
   end
endmodule

// File: rtl/inv_dispatch_chk.sv
module inv_dispatch_chk #(
   parameter int SID_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             cmd_valid,
   input logic [7:0]       cmd_op,
   input logic             cmd_secure,
   input logic             cap_s1,
   input logic             cap_s2,
   input logic             cfg_flush_valid,
   input logic [SID_W-1:0] cfg_sid_lo,
   input logic [SID_W-1:0] cfg_sid_hi,
   input logic             tlb_inv_valid,
   input logic             err_valid,
   input logic [1:0]       err_code
);
   a_r1_one_result: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({cfg_flush_valid, tlb_inv_valid, err_valid}));

   a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !cmd_valid |=> !(cfg_flush_valid || tlb_inv_valid || err_valid));

   a_r2_secure_cfg: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid && cmd_secure && (cmd_op == 8'h03 || cmd_op == 8'h05 || cmd_op == 8'h06)
      |=> err_valid && err_code == 2'd1);

   a_r4_span_order: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_flush_valid |-> cfg_sid_lo <= cfg_sid_hi);

   a_r5_no_stage1: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid && !cap_s1 && (cmd_op == 8'h10 || cmd_op == 8'h11 || cmd_op == 8'h12)
      |=> err_valid);

   a_r9_no_stage2: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid && !cap_s2 && (cmd_op == 8'h28 || cmd_op == 8'h2A)
      |=> err_valid);

   a_r11_code_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !err_valid |-> err_code == 2'd0);

   a_r11_code_set: assert property (@(posedge clk) disable iff (!rst_n)
      err_valid |-> err_code != 2'd0);
endmodule

bind inv_dispatch inv_dispatch_chk #(.SID_W(SID_W)) u_chk (
   .clk             (clk),
   .rst_n           (rst_n),
   .cmd_valid       (cmd_valid),
   .cmd_op          (cmd_op),
   .cmd_secure      (cmd_secure),
   .cap_s1          (cap_s1),
   .cap_s2          (cap_s2),
   .cfg_flush_valid (cfg_flush_valid),
   .cfg_sid_lo      (cfg_sid_lo),
   .cfg_sid_hi      (cfg_sid_hi),
   .tlb_inv_valid   (tlb_inv_valid),
   .err_valid       (err_valid),
   .err_code        (err_code)
);

// File: tb/tb_inv_dispatch.sv
`timescale 1ns/1ps
module tb_inv_dispatch;
   localparam logic [7:0] C_SID = 8'h03, C_SPAN = 8'h04, C_CTX = 8'h05, C_CTXA = 8'h06;
   localparam logic [7:0] T_S1A = 8'h10, T_ASID = 8'h11, T_ADDR = 8'h12;
   localparam logic [7:0] T_VM = 8'h28, T_IPA = 8'h2A, T_GLB = 8'h30;
   localparam logic [1:0] K_NONE = 0, K_CFG = 1, K_TLB = 2, K_ERR = 3;

   typedef struct packed {
      logic [7:0]  op;
      logic [15:0] sid;
      logic        sec;
      logic [15:0] asid;
      logic [15:0] vmid;
      logic [4:0]  rng;
      logic        dev, s1, s2;
      logic [1:0]  kind;
      logic [15:0] lo, hi;
      logic [2:0]  scope;
      logic [15:0] easid, evmid;
      logic        eany;
      logic [3:0]  req;
   } vec_t;

   localparam int NV = 25;
   localparam vec_t VECS [NV] = '{
      '{C_SID,  16'h1234,1,0,0,0,1,1,1, K_ERR, 0,0,0,0,0,0, 4'd2},            // R2
      '{C_CTX,  16'h0042,1,0,0,0,1,1,1, K_ERR, 0,0,0,0,0,0, 4'd2},            // R2
      '{C_CTXA, 16'h0042,1,0,0,0,0,1,1, K_ERR, 0,0,0,0,0,0, 4'd2},            // R2
      '{C_SID,  16'h1234,0,0,0,0,1,1,1, K_CFG, 16'h1234,16'h1234,0,0,0,0, 4'd3}, // R3
      '{C_CTX,  16'h00FF,0,0,0,0,1,0,0, K_CFG, 16'h00FF,16'h00FF,0,0,0,0, 4'd3}, // R3
      '{C_CTXA, 16'h0077,0,0,0,0,0,1,1, K_NONE,0,0,0,0,0,0, 4'd3},            // R3
      '{C_SPAN, 16'h1234,0,0,0,3,0,1,1, K_CFG, 16'h1230,16'h123F,0,0,0,0, 4'd4}, // R4
      '{C_SPAN, 16'hABCD,0,0,0,0,0,1,1, K_CFG, 16'hABCC,16'hABCD,0,0,0,0, 4'd4}, // R4
      '{C_SPAN, 16'hABCD,0,0,0,15,1,1,1,K_CFG, 16'h0000,16'hFFFF,0,0,0,0, 4'd4}, // R4
      '{C_SPAN, 16'h5555,0,0,0,20,1,1,1,K_CFG, 16'h0000,16'hFFFF,0,0,0,0, 4'd4}, // R4
      '{T_ASID, 0,0,16'h0055,16'h0007,0,0,1,1, K_TLB, 0,0,3'd2,16'h0055,16'h0007,0, 4'd6}, // R6
      '{T_ASID, 0,0,16'h0055,16'h0007,0,0,1,0, K_TLB, 0,0,3'd2,16'h0055,16'h0000,1, 4'd6}, // R6
      '{T_ASID, 0,0,16'h0055,16'h0007,0,0,0,1, K_ERR, 0,0,0,0,0,0, 4'd5},     // R5
      '{T_S1A,  0,0,16'h0011,16'h0009,0,0,1,1, K_TLB, 0,0,3'd1,16'h0000,16'h0009,0, 4'd7}, // R7
      '{T_S1A,  0,0,16'h0011,16'h0009,0,0,1,0, K_TLB, 0,0,3'd0,16'h0000,16'h0000,1, 4'd7}, // R7
      '{T_S1A,  0,0,0,0,0,0,0,0, K_ERR, 0,0,0,0,0,0, 4'd5},                   // R5
      '{T_ADDR, 0,0,16'h0AA0,16'h0003,0,0,1,1, K_TLB, 0,0,3'd3,16'h0AA0,16'h0003,0, 4'd10}, // R10
      '{T_ADDR, 0,0,16'h0AA0,16'h0003,0,0,1,0, K_TLB, 0,0,3'd3,16'h0AA0,16'h0000,1, 4'd10}, // R10
      '{T_ADDR, 0,0,16'h0AA0,16'h0003,0,0,0,1, K_ERR, 0,0,0,0,0,0, 4'd5},     // R5
      '{T_GLB,  0,0,16'h0001,16'h0002,0,0,0,0, K_TLB, 0,0,3'd0,0,0,1, 4'd8},  // R8
      '{T_VM,   0,0,16'h0001,16'h0021,0,0,0,1, K_TLB, 0,0,3'd4,16'h0000,16'h0021,0, 4'd9}, // R9
      '{T_VM,   0,0,16'h0001,16'h0021,0,0,1,0, K_ERR, 0,0,0,0,0,0, 4'd9},     // R9
      '{T_IPA,  0,0,16'h0001,16'h0033,0,0,1,1, K_TLB, 0,0,3'd5,16'h0000,16'h0033,0, 4'd9}, // R9
      '{T_IPA,  0,0,0,16'h0033,0,0,1,0, K_ERR, 0,0,0,0,0,0, 4'd9},            // R9
      '{8'h7E,  0,0,0,0,0,1,1,1, K_ERR, 0,0,0,0,0,0, 4'd11}                   // R11
   };

   logic clk = 1'b0, rst_n = 1'b0;
   logic cmd_valid = 1'b0, cmd_secure = 1'b0, dev_present = 1'b0, cap_s1 = 1'b0, cap_s2 = 1'b0;
   logic [7:0]  cmd_op = '0;
   logic [15:0] cmd_sid = '0, cmd_asid = '0, cmd_vmid = '0;
   logic [4:0]  cmd_range = '0;
   logic cfg_flush_valid, tlb_inv_valid, tlb_vmid_any, err_valid;
   logic [15:0] cfg_sid_lo, cfg_sid_hi, tlb_asid, tlb_vmid;
   logic [2:0]  tlb_scope;
   logic [1:0]  err_code;
   int checks = 0, errors = 0, cycles = 0;

   always #10 clk = ~clk;

   inv_dispatch dut (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
      .cmd_sid(cmd_sid), .cmd_secure(cmd_secure), .cmd_asid(cmd_asid),
      .cmd_vmid(cmd_vmid), .cmd_range(cmd_range), .dev_present(dev_present),
      .cap_s1(cap_s1), .cap_s2(cap_s2), .cfg_flush_valid(cfg_flush_valid),
      .cfg_sid_lo(cfg_sid_lo), .cfg_sid_hi(cfg_sid_hi), .tlb_inv_valid(tlb_inv_valid),
      .tlb_scope(tlb_scope), .tlb_asid(tlb_asid), .tlb_vmid(tlb_vmid),
      .tlb_vmid_any(tlb_vmid_any), .err_valid(err_valid), .err_code(err_code)
   );

   task automatic finish_run();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   endtask

   always @(posedge clk) begin
      cycles <= cycles + 1;
      if (cycles > 5000) begin
         checks++;
         errors++;
         $display("FAIL watchdog: run hung, actual cycles=%0d expected below 5000", cycles);
         finish_run();
      end
   end

   task automatic check(input bit ok, input string req, input string what,
                        input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   // drive one command at a falling edge, drop it at the next; the result
   // registered at the rising edge in between is sampled there
   task automatic issue(input vec_t v);
      @(negedge clk);
      cmd_valid = 1'b1; cmd_op = v.op; cmd_sid = v.sid; cmd_secure = v.sec;
      cmd_asid = v.asid; cmd_vmid = v.vmid; cmd_range = v.rng;
      dev_present = v.dev; cap_s1 = v.s1; cap_s2 = v.s2;
      @(negedge clk);
      cmd_valid = 1'b0;
   endtask

   task automatic check_vec(input vec_t v);
      logic [2:0] flags, eflags;
      bit ok;
      flags  = {cfg_flush_valid, tlb_inv_valid, err_valid};
      eflags = {v.kind == K_CFG, v.kind == K_TLB, v.kind == K_ERR};
      ok = (flags == eflags);
      if (v.kind == K_CFG) ok = ok && cfg_sid_lo == v.lo && cfg_sid_hi == v.hi;
      if (v.kind == K_TLB) ok = ok && tlb_scope == v.scope && tlb_asid == v.easid
                                  && tlb_vmid == v.evmid && tlb_vmid_any == v.eany;
      if (v.kind == K_ERR) ok = ok && err_code == 2'd1;
      check(ok, $sformatf("R%0d", v.req), $sformatf("op %h", v.op),
            {5'd0, flags, cfg_sid_lo, cfg_sid_hi, tlb_scope, tlb_asid[11:0], tlb_vmid[7:0], tlb_vmid_any, err_code},
            {5'd0, eflags, v.lo, v.hi, v.scope, v.easid[11:0], v.evmid[7:0], v.eany, 2'(v.kind == K_ERR)});
   endtask

   initial begin
      vec_t v;
      repeat (3) @(negedge clk);
      // R1: reset state
      check({cfg_flush_valid, tlb_inv_valid, err_valid, err_code, tlb_scope} == '0,
            "R1", "reset outputs",
            64'({cfg_flush_valid, tlb_inv_valid, err_valid, err_code, tlb_scope}), 64'd0);
      rst_n = 1'b1;

      for (int i = 0; i < NV; i++) begin
         issue(VECS[i]);
         check_vec(VECS[i]);
      end

      // R11: opcode zero is unknown
      v = '{8'h00,0,0,0,0,0,1,1,1,K_ERR,0,0,0,0,0,0,4'd11};
      issue(v);
      check_vec(v);

      // R1: pulse lasts one cycle
      v = '{T_GLB,0,0,0,0,0,0,1,1,K_TLB,0,0,3'd0,0,0,1,4'd8};
      issue(v);
      @(negedge clk);
      check(!(cfg_flush_valid || tlb_inv_valid || err_valid), "R1", "pulse width",
            64'({cfg_flush_valid, tlb_inv_valid, err_valid}), 64'd0);

      // R1: opcode present without cmd_valid has no effect
      @(negedge clk);
      cmd_op = 8'h7E; cmd_secure = 1'b1; cap_s1 = 1'b0; cap_s2 = 1'b0;
      @(negedge clk);
      check(!(cfg_flush_valid || tlb_inv_valid || err_valid) && err_code == 2'd0,
            "R1", "idle input",
            64'({cfg_flush_valid, tlb_inv_valid, err_valid, err_code}), 64'd0);

      // R3: absent device yields neither flush nor error, nor anything later
      v = '{C_SID,16'h0101,0,0,0,0,0,1,1,K_NONE,0,0,0,0,0,0,4'd3};
      issue(v);
      check_vec(v);
      @(negedge clk);
      check(!(cfg_flush_valid || err_valid), "R3", "absent device later",
            64'({cfg_flush_valid, err_valid}), 64'd0);

      finish_run();
   end
endmodule